// File: doc/BRIEF.md
# Single-Bit Hamming ECC Unit for NAND Chunks

This block builds a 24-bit Hamming-style check code over a 512-byte chunk that arrives one byte per clock. Each bit of the chunk has a 12-bit position made of its byte index and its bit index within the byte. The code has two 12-bit halves. One half holds, for every position bit, the parity of the data bits whose position has that bit set. The other half holds the parity of the data bits whose position has that bit clear. A single flipped data bit therefore changes the two halves in complementary patterns, and the changed pattern spells out where the flip is.

A separate accumulator is kept for each chip select. A start pulse clears one accumulator at the beginning of a chunk. A read returns the inverted, packed code of that chip select and clears it in the same step. During the read, the caller supplies the code that was stored with the page. The block compares the two codes and classifies the result as one of four outcomes:
- clean,
- correctable data error, with the byte and bit to flip,
- error in the stored code itself,
- uncorrectable.

The code is inverted on output, so an erased page of all-ones bytes checks clean against an all-ones stored code. Holding the data and flipping the bit are left to the caller.

Top module: `nand_sbecc`

## Requirements
- R1: After reset, `res_vld_o` is low and every accumulator is empty. Reading an empty accumulator returns code 0xFFFFFF.
- R2: For data bit i of the byte at chunk index a, let the position be p = a*8+i. Odd half bit k is the XOR of the data bits whose p has bit k set. Even half bit k is the XOR of the data bits whose p has bit k clear. `code_o` = ~{odd, even}, with the even half in [11:0] and the odd half in [23:12]. The first stored byte is `code_o[7:0]`, then [15:8], then [23:16].
- R3: A full chunk of 512 bytes of 0xFF produces code 0xFFFFFF.
- R4: `res_vld_o` is high exactly one cycle after each cycle with `rd_i` high. The result covers the bytes taken before the cycle of `rd_i`. That read also empties the accumulator of `rd_cs_i`.
- R5: `start_i` empties the accumulator of `start_cs_i`. A byte on the same chip select in the same cycle as a start or a read becomes byte 0 of the new chunk.
- R6: Bytes for one chip select never change the code of another chip select.
- R7: Bytes past CHUNK_BYTES on a chip select are ignored until that chip select is restarted or read.
- R8: A difference of zero between `code_o` and `stored_i` gives `status_o` = 0 (clean).
- R9: If the difference's bits [23:12] XOR its bits [11:0] equal 0xFFF, and bits [23:15] are below CHUNK_BYTES, then `status_o` = 1. In that case `err_byte_o` = difference[23:15] and `err_bit_o` = difference[14:12].
- R10: A complementary difference whose byte index is not below CHUNK_BYTES gives `status_o` = 3.
- R11: A difference with exactly one bit set gives `status_o` = 2, with `err_byte_o` and `err_bit_o` zero.
- R12: Any other nonzero difference gives `status_o` = 3, with `err_byte_o` and `err_bit_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-chunk pulse |
| start_cs_i | input | 2 | Chip select to restart |
| byte_vld_i | input | 1 | Data byte present |
| byte_cs_i | input | 2 | Chip select of the data byte |
| byte_i | input | 8 | Data byte |
| rd_i | input | 1 | Read and compare request |
| rd_cs_i | input | 2 | Chip select to read |
| stored_i | input | 24 | Code stored with the page, bytes packed with the lowest first |
| res_vld_o | output | 1 | Result valid |
| code_o | output | 24 | Computed, inverted code |
| status_o | output | 2 | 0 clean, 1 data fix, 2 code error, 3 uncorrectable |
| err_byte_o | output | 9 | Byte index to fix |
| err_bit_o | output | 3 | Bit index to fix |

## Verification
Two functions can fall in the same cycle on one chip select:
- a clear, from either a start pulse or a read,
- the accumulation of a byte.

The bench drives a start or a read together with a byte for the same chip select. It checks that the concurrent read excludes the byte. It then reads again and checks the code against a literal value computed for that single byte at chunk index 0. A start on one chip select while a byte goes to another checks that the clear stays local.

// File: rtl/nand_sbecc.sv
module nand_sbecc #(
  parameter  int NUM_CS      = 4,
  parameter  int CHUNK_BYTES = 512,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int AW  = $clog2(CHUNK_BYTES),
  localparam int HW  = AW + 3,
  localparam int CW  = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CSW-1:0] start_cs_i,
  input  logic          byte_vld_i,
  input  logic [CSW-1:0] byte_cs_i,
  input  logic [7:0]    byte_i,
  input  logic          rd_i,
  input  logic [CSW-1:0] rd_cs_i,
  input  logic [CW-1:0] stored_i,
  output logic          res_vld_o,
  output logic [CW-1:0] code_o,
  output logic [1:0]    status_o,
  output logic [AW-1:0] err_byte_o,
  output logic [2:0]    err_bit_o
);
  localparam logic [1:0] ST_CLEAN = 2'd0;
  localparam logic [1:0] ST_FIX   = 2'd1;
  localparam logic [1:0] ST_CODE  = 2'd2;
  localparam logic [1:0] ST_BAD   = 2'd3;

  logic [HW-1:0] od_q  [NUM_CS];
  logic [HW-1:0] ev_q  [NUM_CS];
  logic [AW:0]   cnt_q [NUM_CS];

  logic [NUM_CS-1:0] clr_v, hit_v;
  logic [HW-1:0] b_od, b_ev;
  logic [AW-1:0] b_addr;
  logic          b_clr, b_take;

  always_comb begin
    for (int c = 0; c < NUM_CS; c++) begin
      clr_v[c] = (start_i && start_cs_i == CSW'(c)) || (rd_i && rd_cs_i == CSW'(c));
      hit_v[c] = b_take && byte_cs_i == CSW'(c);
    end
  end

  assign b_clr  = clr_v[byte_cs_i];
  assign b_addr = b_clr ? '0 : cnt_q[byte_cs_i][AW-1:0];
  assign b_take = byte_vld_i && (b_clr || cnt_q[byte_cs_i] < (AW+1)'(CHUNK_BYTES));

  always_comb begin
    b_od = '0;
    b_ev = '0;
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 8; i++)
        if (((i >> k) & 1) != 0) b_od[k] = b_od[k] ^ byte_i[i];
        else                     b_ev[k] = b_ev[k] ^ byte_i[i];
    for (int j = 0; j < AW; j++) begin
      b_od[3+j] =  b_addr[j] & (^byte_i);
      b_ev[3+j] = ~b_addr[j] & (^byte_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CS; c++) begin
        od_q[c]  <= '0;
        ev_q[c]  <= '0;
        cnt_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CS; c++) begin
        if (hit_v[c]) begin
          od_q[c]  <= (clr_v[c] ? '0 : od_q[c]) ^ b_od;
          ev_q[c]  <= (clr_v[c] ? '0 : ev_q[c]) ^ b_ev;
          cnt_q[c] <= (clr_v[c] ? '0 : cnt_q[c]) + (AW+1)'(1);
        end else if (clr_v[c]) begin
          od_q[c]  <= '0;
          ev_q[c]  <= '0;
          cnt_q[c] <= '0;
        end
      end
    end
  end

  logic [CW-1:0] calc, diff;
  logic [HW-1:0] d_lo, d_hi;
  logic [AW-1:0] d_byte;
  logic [1:0]    st;

  assign calc   = ~{od_q[rd_cs_i], ev_q[rd_cs_i]};
  assign diff   = calc ^ stored_i;
  assign d_lo   = diff[HW-1:0];
  assign d_hi   = diff[CW-1:HW];
  assign d_byte = d_hi[HW-1:3];

  always_comb begin
    if (diff == '0)                       st = ST_CLEAN;
    else if ((d_hi ^ d_lo) == '1)         st = ({1'b0, d_byte} < (AW+1)'(CHUNK_BYTES)) ? ST_FIX : ST_BAD;
    else if ((diff & (diff - 1'b1)) == '0) st = ST_CODE;
    else                                  st = ST_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_o  <= 1'b0;
      code_o     <= '0;
      status_o   <= ST_CLEAN;
      err_byte_o <= '0;
      err_bit_o  <= '0;
    end else begin
      res_vld_o <= rd_i;
      if (rd_i) begin
        code_o     <= calc;
        status_o   <= st;
        err_byte_o <= (st == ST_FIX) ? d_byte : '0;
        err_bit_o  <= (st == ST_FIX) ? d_hi[2:0] : 3'd0;
      end
    end
  end
endmodule

// File: rtl/nand_sbecc_chk.sv
module nand_sbecc_chk #(
  parameter  int NUM_CS      = 4,
  parameter  int CHUNK_BYTES = 512,
  localparam int AW = $clog2(CHUNK_BYTES),
  localparam int HW = AW + 3,
  localparam int CW = 2 * HW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_i,
  input logic [CW-1:0] stored_i,
  input logic          res_vld_o,
  input logic [CW-1:0] code_o,
  input logic [1:0]    status_o,
  input logic [AW-1:0] err_byte_o,
  input logic [2:0]    err_bit_o
);
  logic [CW-1:0] stored_q;
  always_ff @(posedge clk) stored_q <= stored_i;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !res_vld_o);

  assert_result_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> res_vld_o);

  assert_no_spurious_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !res_vld_o);

  assert_clean_means_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && status_o == 2'd0) |-> code_o == stored_q);

  assert_fix_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && status_o == 2'd1) |->
      ({1'b0, err_byte_o} < (AW+1)'(CHUNK_BYTES)) &&
      (({err_byte_o, err_bit_o} ^ code_o[HW-1:0] ^ stored_q[HW-1:0]) == '1));

  assert_code_error_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && status_o == 2'd2) |->
      $onehot(code_o ^ stored_q) && err_byte_o == '0 && err_bit_o == '0);

  assert_uncorrectable_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && status_o == 2'd3) |->
      (code_o ^ stored_q) != '0 && err_byte_o == '0 && err_bit_o == '0);
endmodule

bind nand_sbecc nand_sbecc_chk #(.NUM_CS(NUM_CS), .CHUNK_BYTES(CHUNK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .stored_i(stored_i),
  .res_vld_o(res_vld_o), .code_o(code_o), .status_o(status_o),
  .err_byte_o(err_byte_o), .err_bit_o(err_bit_o)
);

// File: tb/nand_sbecc_bench.sv
`timescale 1ns/1ps
module nand_sbecc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic st_i = 0, bv_i = 0, rd_i = 0;
  logic [1:0] st_cs = 0, b_cs = 0, r_cs = 0;
  logic [7:0] b_dat = 0;
  logic [23:0] stored = 0;

  logic        vld  [2];
  logic [23:0] code [2];
  logic [1:0]  stat [2];
  logic [8:0]  eb   [2];
  logic [2:0]  ebit [2];

  nand_sbecc #(.NUM_CS(4), .CHUNK_BYTES(512)) u_nand_sbecc (
    .clk(clk), .rst_n(rst_n), .start_i(st_i), .start_cs_i(st_cs),
    .byte_vld_i(bv_i), .byte_cs_i(b_cs), .byte_i(b_dat),
    .rd_i(rd_i), .rd_cs_i(r_cs), .stored_i(stored),
    .res_vld_o(vld[0]), .code_o(code[0]), .status_o(stat[0]),
    .err_byte_o(eb[0]), .err_bit_o(ebit[0]));

  nand_sbecc #(.NUM_CS(4), .CHUNK_BYTES(300)) u_nand_sbecc_short (
    .clk(clk), .rst_n(rst_n), .start_i(st_i), .start_cs_i(st_cs),
    .byte_vld_i(bv_i), .byte_cs_i(b_cs), .byte_i(b_dat),
    .rd_i(rd_i), .rd_cs_i(r_cs), .stored_i(stored),
    .res_vld_o(vld[1]), .code_o(code[1]), .status_o(stat[1]),
    .err_byte_o(eb[1]), .err_bit_o(ebit[1]));

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit run = 0, done = 0;
  logic [7:0] page [512];

  function automatic int chunk_of(int d);
    return (d == 0) ? 512 : 300;
  endfunction

  // behavioural reference: positions of set bits XORed into the halves
  int          m_cnt [2][4];
  logic [11:0] m_od  [2][4];
  logic [11:0] m_ev  [2][4];
  logic        e_vld [2];
  logic [23:0] e_code[2];
  logic [1:0]  e_st  [2];
  logic [8:0]  e_eb  [2];
  logic [2:0]  e_bit [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        e_vld[d] = 0;
        for (int c = 0; c < 4; c++) begin m_cnt[d][c] = 0; m_od[d][c] = 0; m_ev[d][c] = 0; end
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        e_vld[d] = rd_i;
        if (rd_i) begin
          logic [23:0] df;
          logic [11:0] hi, lo;
          e_code[d] = ~{m_od[d][r_cs], m_ev[d][r_cs]};
          df = e_code[d] ^ stored;
          hi = df[23:12]; lo = df[11:0];
          e_eb[d] = 0; e_bit[d] = 0;
          if (df == 0) e_st[d] = 0;
          else if ((hi ^ lo) == 12'hFFF) begin
            if (int'(hi >> 3) < chunk_of(d)) begin
              e_st[d] = 1; e_eb[d] = 9'(hi >> 3); e_bit[d] = hi[2:0];
            end else e_st[d] = 3;
          end else if ($countones(df) == 1) e_st[d] = 2;
          else e_st[d] = 3;
        end
        if (st_i) begin m_cnt[d][st_cs] = 0; m_od[d][st_cs] = 0; m_ev[d][st_cs] = 0; end
        if (rd_i) begin m_cnt[d][r_cs] = 0; m_od[d][r_cs] = 0; m_ev[d][r_cs] = 0; end
        if (bv_i && m_cnt[d][b_cs] < chunk_of(d)) begin
          for (int i = 0; i < 8; i++)
            if (b_dat[i]) begin
              logic [11:0] p;
              p = 12'(m_cnt[d][b_cs] * 8 + i);
              m_od[d][b_cs] ^= p;
              m_ev[d][b_cs] ^= ~p;
            end
          m_cnt[d][b_cs]++;
        end
      end
    end
  end

  task automatic chk(string what, int d, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s dut%0d actual=%h expected=%h", cur_req, what, d, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      for (int d = 0; d < 2; d++) begin
        chk("res_vld", d, 32'(vld[d]), 32'(e_vld[d]));
        if (e_vld[d]) begin
          chk("code", d, 32'(code[d]), 32'(e_code[d]));
          chk("status", d, 32'(stat[d]), 32'(e_st[d]));
          chk("err_byte", d, 32'(eb[d]), 32'(e_eb[d]));
          chk("err_bit", d, 32'(ebit[d]), 32'(e_bit[d]));
        end
      end
    end
  end

  task automatic cyc(bit s, int sc, bit v, int vc, logic [7:0] b, bit r, int rc, logic [23:0] sd);
    @(negedge clk);
    st_i = s; st_cs = 2'(sc); bv_i = v; b_cs = 2'(vc); b_dat = b;
    rd_i = r; r_cs = 2'(rc); stored = sd;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 8'h00, 0, 0, 24'h0);
  endtask

  task automatic stream_page(int cs, int n);
    for (int a = 0; a < n; a++) cyc(0, 0, 1, cs, page[a], 0, 0, 24'h0);
  endtask

  task automatic read_cs(int cs, logic [23:0] sd);
    cyc(0, 0, 0, 0, 8'h00, 1, cs, sd);
    idle();
  endtask

  task automatic dchk(int d, logic [23:0] ec, logic [1:0] es, logic [8:0] eeb, logic [2:0] ebt);
    chk("direct res_vld", d, 32'(vld[d]), 32'd1);
    chk("direct code", d, 32'(code[d]), 32'(ec));
    chk("direct status", d, 32'(stat[d]), 32'(es));
    chk("direct err_byte", d, 32'(eb[d]), 32'(eeb));
    chk("direct err_bit", d, 32'(ebit[d]), 32'(ebt));
  endtask

  function automatic logic [23:0] ref_code(int n);
    logic [11:0] o = 0, e = 0;
    for (int a = 0; a < n; a++)
      for (int i = 0; i < 8; i++)
        if (page[a][i]) begin o ^= 12'(a * 8 + i); e ^= ~12'(a * 8 + i); end
    return ~{o, e};
  endfunction

  initial begin
    logic [23:0] orig;
    logic [11:0] p;
    repeat (4) @(negedge clk);
    rst_n = 1;
    run = 1;

    cur_req = "R1";
    @(negedge clk);
    chk("reset res_vld", 0, 32'(vld[0]), 32'd0);
    chk("reset res_vld", 1, 32'(vld[1]), 32'd0);
    read_cs(2, 24'hFFFFFF);
    dchk(0, 24'hFFFFFF, 0, 0, 0);

    cur_req = "R3";
    for (int a = 0; a < 512; a++) page[a] = 8'hFF;
    stream_page(0, 512);
    read_cs(0, 24'hFFFFFF);
    dchk(0, 24'hFFFFFF, 0, 0, 0);

    cur_req = "R2";
    cyc(0, 0, 1, 2, 8'h01, 0, 0, 24'h0);
    read_cs(2, 24'hFFF000);
    dchk(0, 24'hFFF000, 0, 0, 0);
    cyc(0, 0, 1, 2, 8'h00, 0, 0, 24'h0);
    cyc(0, 0, 1, 2, 8'h80, 0, 0, 24'h0);
    read_cs(2, 24'hFF000F);
    dchk(0, 24'hFF000F, 0, 0, 0);

    cur_req = "R8";
    for (int a = 0; a < 512; a++) page[a] = 8'($urandom);
    orig = ref_code(512);
    stream_page(1, 512);
    read_cs(1, orig);
    dchk(0, orig, 0, 0, 0);

    cur_req = "R9";
    page[77][5] = ~page[77][5];
    stream_page(1, 512);
    read_cs(1, orig);
    chk("fix status", 0, 32'(stat[0]), 32'd1);
    chk("fix byte", 0, 32'(eb[0]), 32'd77);
    chk("fix bit", 0, 32'(ebit[0]), 32'd5);
    page[77][5] = ~page[77][5];

    cur_req = "R11";
    stream_page(3, 512);
    read_cs(3, orig ^ 24'h000400);
    dchk(0, orig, 2, 0, 0);

    cur_req = "R12";
    stream_page(3, 512);
    read_cs(3, orig ^ 24'h000003);
    dchk(0, orig, 3, 0, 0);
    stream_page(3, 200);
    read_cs(3, orig ^ 24'h810200);

    cur_req = "R10";
    p = 12'(400 * 8 + 3);
    read_cs(2, 24'hFFFFFF ^ {p, ~p});
    dchk(0, 24'hFFFFFF, 1, 9'd400, 3'd3);
    dchk(1, 24'hFFFFFF, 3, 0, 0);

    cur_req = "R7";
    for (int a = 0; a < 512; a++) page[a] = 8'(a) ^ 8'h5A;
    orig = ref_code(512);
    stream_page(2, 512);
    for (int a = 0; a < 8; a++) cyc(0, 0, 1, 2, 8'hC3, 0, 0, 24'h0);
    read_cs(2, orig);
    dchk(0, orig, 0, 0, 0);
    chk("short code", 1, 32'(code[1]), 32'(ref_code(300)));

    cur_req = "R6";
    for (int a = 0; a < 64; a++) begin
      cyc(0, 0, 1, 0, 8'(a * 3 + 1), 0, 0, 24'h0);
      cyc(a == 10, 1, 1, 3, 8'(a ^ 8'hA5), 0, 0, 24'h0);
    end
    read_cs(0, 24'h0);
    read_cs(3, 24'h0);
    read_cs(1, 24'hFFFFFF);
    dchk(0, 24'hFFFFFF, 0, 0, 0);

    cur_req = "R5";
    for (int a = 0; a < 10; a++) cyc(0, 0, 1, 0, 8'hE7, 0, 0, 24'h0);
    cyc(1, 0, 1, 0, 8'h01, 0, 0, 24'h0);
    read_cs(0, 24'hFFF000);
    dchk(0, 24'hFFF000, 0, 0, 0);
    for (int a = 0; a < 5; a++) cyc(0, 0, 1, 1, 8'h3C, 0, 0, 24'h0);
    cyc(0, 0, 1, 1, 8'h80, 1, 1, 24'h0);
    idle();
    read_cs(1, 24'hFF8007);
    dchk(0, 24'hFF8007, 0, 0, 0);

    cur_req = "R4";
    for (int a = 0; a < 20; a++) cyc(0, 0, 1, 2, 8'h11, 0, 0, 24'h0);
    cyc(0, 0, 0, 0, 8'h00, 1, 2, 24'h0);
    cyc(0, 0, 0, 0, 8'h00, 1, 2, 24'hFFFFFF);
    idle();
    dchk(0, 24'hFFFFFF, 0, 0, 0);
    repeat (4) idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule